// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block is the 64-byte configuration header of one PCI function, reached through a simple request port. Each request carries a byte offset, an access size in bytes, a write flag and write data. One cycle later the block returns a response: read data in the low bytes (little-endian), or an error flag.

The header holds the function's identity fields, the command and status halfwords, the cache-line and latency bytes, the interrupt bytes, six base address registers (BARs) and the expansion ROM base register. The reset contents and the window size of each BAR come from parameters.

What a write may change depends on both the access size and the offset. A BAR keeps its low type bits when written. A BAR answers an all-ones write, a sizing probe, with the complement of its size minus one. A write to any location the rules do not allow is rejected: it raises the error flag and changes nothing. Bus signalling, BAR window decoding, capability lists and the status error bits are outside this block.

Top module: `pci_cfg_header`

## Requirements
- R1: Every request with `reqValid` high produces `rspValid` high for exactly one cycle, in the cycle after the request. `rspErr` is high in that same cycle only when the request was rejected. With no request there is no response. A write response, and any rejected request, returns `rspData` = 0.
- R2: A read of size 1, 2 or 4 at any offset with offset + size ≤ 64 returns the stored bytes. The byte at the request offset goes in bits 7:0, the following bytes go above it, and unused upper bytes read 0. Any other read size (0, 3, 5, 6, 7), or a read that runs past byte 63, is rejected.
- R3: After reset the header holds the parameter values at the standard offsets: vendor 0x00, device 0x02, command 0x04, status 0x06, revision 0x08, programming interface 0x09, subclass 0x0A, class 0x0B, cache line 0x0C, latency 0x0D, header type 0x0E, BIST 0x0F, BARs 0x10–0x24, card information pointer 0x28, subsystem vendor 0x2C, subsystem 0x2E, ROM base 0x30, interrupt line 0x3C, interrupt pin 0x3D, minimum grant 0x3E, maximum latency 0x3F. All other bytes are 0.
- R4: A 1-byte write changes the byte only at offset 0x0C or 0x3C. A 1-byte write to any other offset is rejected.
- R5: A 2-byte write is accepted only at offset 0x04 (command), 0x06 (status) or 0x0C (bytes 0x0C–0x0D). A 2-byte write anywhere else is rejected.
- R6: A write of size 3, or of any size other than 1, 2 or 4, is rejected.
- R7: A 4-byte write at offset 0x04 updates only the command halfword from write bits 15:0. The status halfword keeps its value.
- R8: The current bit 0 of a BAR selects its type. If bit 0 is 1, the BAR maps I/O space and its bits 1:0 are read-only. If bit 0 is 0, the BAR maps memory and its bits 3:0 are read-only. A 4-byte write of any value other than 0xFFFFFFFF to a BAR (offsets 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24) stores the written value in the writable bits and leaves the read-only bits as they were.
- R9: A 4-byte write of 0xFFFFFFFF to BAR n loads it with ~(size_n − 1) in the writable bits and keeps its read-only type bits.
- R10: A 4-byte write of 0xFFFFFFFE to offset 0x30 makes that register read 0xFFFFFFFF. Any other 4-byte value written there is stored as written.
- R11: A 4-byte write to any offset other than a BAR, 0x04 or 0x30 is rejected. A rejected write of any size leaves every header byte unchanged, including all identity fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | 6 | Byte offset into the header |
| reqSize | input | 3 | Access size in bytes |
| reqWdata | input | 32 | Write data, little-endian in the low bytes |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspData | output | 32 | Read data, 0 for writes and errors |
| rspErr | output | 1 | Request was rejected |

## Verification
Each response is due exactly one clock edge after the request is captured. A write becomes visible to the next read request issued behind it. The bench drives each request on a falling edge and samples the response flags and data on the next falling edge. That falls one register stage after the capturing rising edge, away from any active edge. Rejected writes are confirmed by reading the affected locations back through the same port, before any other write touches them.

// File: rtl/pci_cfg_header_pkg.sv
package pci_cfg_header_pkg;
  localparam int HDR_BYTES = 64;
  localparam int OFF_W     = $clog2(HDR_BYTES);
  localparam int NUM_BARS  = 6;
  localparam int BAR_IDX_W = $clog2(NUM_BARS);

  localparam logic [OFF_W-1:0] OFF_CMD     = OFF_W'('h04);
  localparam logic [OFF_W-1:0] OFF_STAT    = OFF_W'('h06);
  localparam logic [OFF_W-1:0] OFF_CLS     = OFF_W'('h0C);
  localparam logic [OFF_W-1:0] OFF_BAR0    = OFF_W'('h10);
  localparam logic [OFF_W-1:0] OFF_BARLAST = OFF_W'('h10 + 4 * (NUM_BARS - 1));
  localparam logic [OFF_W-1:0] OFF_ROM     = OFF_W'('h30);
  localparam logic [OFF_W-1:0] OFF_INTLINE = OFF_W'('h3C);

  // Strobes from control to datapath
  typedef struct packed {
    logic                 ack;     // a request was present
    logic                 reject;  // request refused
    logic                 rdEn;    // legal read
    logic                 wrByte;  // write wdata[7:0] at offset
    logic                 wrHalf;  // write wdata[15:0] at offset
    logic                 wrBar;   // BAR word write
    logic                 wrRom;   // ROM base word write
    logic [BAR_IDX_W-1:0] barIdx;
  } hdrStrobe_t;
endpackage

// File: rtl/pci_cfg_header_ctrl.sv
module pci_cfg_header_ctrl
  import pci_cfg_header_pkg::*;
(
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [2:0]       reqSize,
  output hdrStrobe_t       strb
);
  logic [OFF_W:0] endPos;
  logic           sizeOk;
  logic           endOk;
  logic           barHit;
  logic [OFF_W-1:0] barRel;

  assign endPos = {1'b0, reqOffset} + {{(OFF_W-2){1'b0}}, reqSize};
  assign endOk  = endPos <= (OFF_W+1)'(HDR_BYTES);
  assign sizeOk = (reqSize == 3'd1) || (reqSize == 3'd2) || (reqSize == 3'd4);
  assign barHit = (reqOffset >= OFF_BAR0) && (reqOffset <= OFF_BARLAST) && (reqOffset[1:0] == 2'b00);
  assign barRel = reqOffset - OFF_BAR0;

  always_comb begin
    strb = '0;
    if (reqValid) begin
      strb.ack = 1'b1;
      if (!reqWrite) begin
        if (sizeOk && endOk) strb.rdEn = 1'b1;
        else                 strb.reject = 1'b1;
      end else begin
        case (reqSize)
          3'd1: begin
            if (reqOffset == OFF_CLS || reqOffset == OFF_INTLINE) strb.wrByte = 1'b1;
            else strb.reject = 1'b1;
          end
          3'd2: begin
            if (reqOffset == OFF_CMD || reqOffset == OFF_STAT || reqOffset == OFF_CLS)
              strb.wrHalf = 1'b1;
            else strb.reject = 1'b1;
          end
          3'd4: begin
            if (barHit) begin
              strb.wrBar  = 1'b1;
              strb.barIdx = BAR_IDX_W'(barRel >> 2);
            end else if (reqOffset == OFF_ROM) begin
              strb.wrRom = 1'b1;
            end else if (reqOffset == OFF_CMD) begin
              strb.wrHalf = 1'b1;  // command only, status untouched
            end else begin
              strb.reject = 1'b1;
            end
          end
          default: strb.reject = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/pci_cfg_header_dp.sv
module pci_cfg_header_dp
  import pci_cfg_header_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID   = 16'h7301,
  parameter logic [15:0] CMD_INIT    = 16'h0000,
  parameter logic [15:0] STAT_INIT   = 16'h0290,
  parameter logic [7:0]  REVISION    = 8'h02,
  parameter logic [7:0]  PROG_IF     = 8'h00,
  parameter logic [7:0]  SUB_CLASS   = 8'h00,
  parameter logic [7:0]  CLASS_CODE  = 8'h02,
  parameter logic [7:0]  CLS_INIT    = 8'h00,
  parameter logic [7:0]  LAT_INIT    = 8'h00,
  parameter logic [7:0]  HDR_TYPE    = 8'h00,
  parameter logic [7:0]  BIST_VAL    = 8'h00,
  parameter logic [NUM_BARS*32-1:0] BAR_INIT = {32'h0, 32'h0, 32'h0, 32'h0, 32'h8, 32'h1},
  parameter logic [NUM_BARS*32-1:0] BAR_SIZE = {32'h10, 32'h10, 32'h10, 32'h10, 32'h1000, 32'h100},
  parameter logic [31:0] CIS_PTR     = 32'h0,
  parameter logic [15:0] SUBSYS_VID  = 16'h1AB5,
  parameter logic [15:0] SUBSYS_ID   = 16'h0042,
  parameter logic [31:0] ROM_INIT    = 32'h0,
  parameter logic [7:0]  INT_LINE    = 8'h0B,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [7:0]  MIN_GNT     = 8'h06,
  parameter logic [7:0]  MAX_LAT     = 8'h10
) (
  input  logic             clk,
  input  logic             rstN,
  input  hdrStrobe_t       strb,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [2:0]       reqSize,
  input  logic [31:0]      reqWdata,
  output logic             rspValid,
  output logic             rspErr,
  output logic [31:0]      rspData
);
  function automatic logic [HDR_BYTES*8-1:0] resetImage();
    logic [HDR_BYTES*8-1:0] img;
    img = '0;
    img[8*'h00 +: 16] = VENDOR_ID;
    img[8*'h02 +: 16] = DEVICE_ID;
    img[8*'h04 +: 16] = CMD_INIT;
    img[8*'h06 +: 16] = STAT_INIT;
    img[8*'h08 +: 8]  = REVISION;
    img[8*'h09 +: 8]  = PROG_IF;
    img[8*'h0A +: 8]  = SUB_CLASS;
    img[8*'h0B +: 8]  = CLASS_CODE;
    img[8*'h0C +: 8]  = CLS_INIT;
    img[8*'h0D +: 8]  = LAT_INIT;
    img[8*'h0E +: 8]  = HDR_TYPE;
    img[8*'h0F +: 8]  = BIST_VAL;
    for (int b = 0; b < NUM_BARS; b++) img[8*('h10 + 4*b) +: 32] = BAR_INIT[32*b +: 32];
    img[8*'h28 +: 32] = CIS_PTR;
    img[8*'h2C +: 16] = SUBSYS_VID;
    img[8*'h2E +: 16] = SUBSYS_ID;
    img[8*'h30 +: 32] = ROM_INIT;
    img[8*'h3C +: 8]  = INT_LINE;
    img[8*'h3D +: 8]  = INT_PIN;
    img[8*'h3E +: 8]  = MIN_GNT;
    img[8*'h3F +: 8]  = MAX_LAT;
    return img;
  endfunction

  localparam logic [HDR_BYTES*8-1:0] RESET_IMG = resetImage();

  logic [7:0]  hdr [HDR_BYTES];
  logic [31:0] curWord, barSize, lowMask, barNew, romNew, wordNew, rdWord;
  logic [OFF_W-1:0] offPlus [4];

  for (genvar g = 0; g < 4; g++) begin : g_off
    assign offPlus[g] = reqOffset + OFF_W'(g);
  end

  assign curWord = {hdr[offPlus[3]], hdr[offPlus[2]], hdr[offPlus[1]], hdr[offPlus[0]]};
  assign barSize = BAR_SIZE[32*int'(strb.barIdx) +: 32];
  assign lowMask = curWord[0] ? 32'h0000_0003 : 32'h0000_000F;
  assign barNew  = (reqWdata == 32'hFFFF_FFFF)
                 ? ((~(barSize - 32'd1) & ~lowMask) | (curWord & lowMask))
                 : ((reqWdata & ~lowMask) | (curWord & lowMask));
  assign romNew  = (reqWdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : reqWdata;
  assign wordNew = strb.wrBar ? barNew : romNew;

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < 4; i++)
      if (3'(i) < reqSize) rdWord[8*i +: 8] = hdr[offPlus[i]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HDR_BYTES; i++) hdr[i] <= RESET_IMG[8*i +: 8];
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.ack;
      rspErr   <= strb.reject;
      rspData  <= strb.rdEn ? rdWord : '0;
      if (strb.wrByte) hdr[offPlus[0]] <= reqWdata[7:0];
      if (strb.wrHalf) begin
        hdr[offPlus[0]] <= reqWdata[7:0];
        hdr[offPlus[1]] <= reqWdata[15:8];
      end
      if (strb.wrBar || strb.wrRom) begin
        for (int i = 0; i < 4; i++) hdr[offPlus[i]] <= wordNew[8*i +: 8];
      end
    end
  end
endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
  import pci_cfg_header_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID   = 16'h7301,
  parameter logic [15:0] CMD_INIT    = 16'h0000,
  parameter logic [15:0] STAT_INIT   = 16'h0290,
  parameter logic [7:0]  REVISION    = 8'h02,
  parameter logic [7:0]  PROG_IF     = 8'h00,
  parameter logic [7:0]  SUB_CLASS   = 8'h00,
  parameter logic [7:0]  CLASS_CODE  = 8'h02,
  parameter logic [7:0]  CLS_INIT    = 8'h00,
  parameter logic [7:0]  LAT_INIT    = 8'h00,
  parameter logic [7:0]  HDR_TYPE    = 8'h00,
  parameter logic [7:0]  BIST_VAL    = 8'h00,
  parameter logic [NUM_BARS*32-1:0] BAR_INIT = {32'h0, 32'h0, 32'h0, 32'h0, 32'h8, 32'h1},
  parameter logic [NUM_BARS*32-1:0] BAR_SIZE = {32'h10, 32'h10, 32'h10, 32'h10, 32'h1000, 32'h100},
  parameter logic [31:0] CIS_PTR     = 32'h0,
  parameter logic [15:0] SUBSYS_VID  = 16'h1AB5,
  parameter logic [15:0] SUBSYS_ID   = 16'h0042,
  parameter logic [31:0] ROM_INIT    = 32'h0,
  parameter logic [7:0]  INT_LINE    = 8'h0B,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [7:0]  MIN_GNT     = 8'h06,
  parameter logic [7:0]  MAX_LAT     = 8'h10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [5:0]  reqOffset,
  input  logic [2:0]  reqSize,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic        rspErr
);
  hdrStrobe_t strb;

  pci_cfg_header_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqOffset(reqOffset),
    .reqSize  (reqSize),
    .strb     (strb)
  );

  pci_cfg_header_dp #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CMD_INIT(CMD_INIT), .STAT_INIT(STAT_INIT),
    .REVISION(REVISION), .PROG_IF(PROG_IF), .SUB_CLASS(SUB_CLASS), .CLASS_CODE(CLASS_CODE),
    .CLS_INIT(CLS_INIT), .LAT_INIT(LAT_INIT), .HDR_TYPE(HDR_TYPE), .BIST_VAL(BIST_VAL),
    .BAR_INIT(BAR_INIT), .BAR_SIZE(BAR_SIZE), .CIS_PTR(CIS_PTR), .SUBSYS_VID(SUBSYS_VID),
    .SUBSYS_ID(SUBSYS_ID), .ROM_INIT(ROM_INIT), .INT_LINE(INT_LINE), .INT_PIN(INT_PIN),
    .MIN_GNT(MIN_GNT), .MAX_LAT(MAX_LAT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqOffset(reqOffset),
    .reqSize  (reqSize),
    .reqWdata (reqWdata),
    .rspValid (rspValid),
    .rspErr   (rspErr),
    .rspData  (rspData)
  );
endmodule

// File: rtl/pci_cfg_header_chk.sv
module pci_cfg_header_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [5:0]  reqOffset,
  input logic [2:0]  reqSize,
  input logic        rspValid,
  input logic [31:0] rspData,
  input logic        rspErr
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);  // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspErr));  // R1
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspData == 32'h0));  // R1
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspData == 32'h0));  // R1
  AST_BAD_READ_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !(reqSize == 3'd1 || reqSize == 3'd2 || reqSize == 3'd4)) |=> rspErr);  // R2
  AST_RO_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == 3'd1 && reqOffset != 6'h0C && reqOffset != 6'h3C) |=> rspErr);  // R4
  AST_BAD_WRITE_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !(reqSize == 3'd1 || reqSize == 3'd2 || reqSize == 3'd4)) |=> rspErr);  // R6
  AST_BAR_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == 3'd4 && reqOffset >= 6'h10 && reqOffset <= 6'h24 &&
     reqOffset[1:0] == 2'b00) |=> !rspErr);  // R8
endmodule

bind pci_cfg_header pci_cfg_header_chk u_chk (.*);

// File: tb/pci_cfg_header_test.sv
`timescale 1ns/1ps
module pci_cfg_header_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [5:0]  reqOffset = '0;
  logic [2:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rspErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pci_cfg_header uut (.*);

  typedef struct packed {
    logic        wr;
    logic [2:0]  sz;
    logic [5:0]  off;
    logic [31:0] wd;
    logic        err;
    logic [31:0] rd;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 44;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 3'd4, 6'h00, 32'h0,        1'b0, 32'h7301_1AB5, 8'd3},   // R3 ids
    '{1'b0, 3'd2, 6'h02, 32'h0,        1'b0, 32'h0000_7301, 8'd2},   // R2 half read
    '{1'b0, 3'd1, 6'h0B, 32'h0,        1'b0, 32'h0000_0002, 8'd2},   // R2 byte read
    '{1'b0, 3'd4, 6'h08, 32'h0,        1'b0, 32'h0200_0002, 8'd3},   // R3 class/rev
    '{1'b0, 3'd4, 6'h3C, 32'h0,        1'b0, 32'h1006_010B, 8'd3},   // R3 interrupt word
    '{1'b1, 3'd1, 6'h3C, 32'h55,       1'b0, 32'h0,         8'd4},   // R4
    '{1'b0, 3'd1, 6'h3C, 32'h0,        1'b0, 32'h0000_0055, 8'd4},
    '{1'b1, 3'd1, 6'h3D, 32'hAA,       1'b1, 32'h0,         8'd4},   // R4 reject
    '{1'b0, 3'd4, 6'h3C, 32'h0,        1'b0, 32'h1006_0155, 8'd11},  // R11 unchanged
    '{1'b1, 3'd1, 6'h0C, 32'h10,       1'b0, 32'h0,         8'd4},
    '{1'b1, 3'd2, 6'h0C, 32'h2040,     1'b0, 32'h0,         8'd5},   // R5
    '{1'b0, 3'd2, 6'h0C, 32'h0,        1'b0, 32'h0000_2040, 8'd5},
    '{1'b1, 3'd2, 6'h04, 32'h0007,     1'b0, 32'h0,         8'd5},
    '{1'b1, 3'd2, 6'h06, 32'h0000,     1'b0, 32'h0,         8'd5},
    '{1'b0, 3'd4, 6'h04, 32'h0,        1'b0, 32'h0000_0007, 8'd5},
    '{1'b1, 3'd4, 6'h04, 32'hFFFF_0106, 1'b0, 32'h0,        8'd7},   // R7
    '{1'b0, 3'd4, 6'h04, 32'h0,        1'b0, 32'h0000_0106, 8'd7},
    '{1'b1, 3'd2, 6'h08, 32'h1234,     1'b1, 32'h0,         8'd5},   // R5 reject
    '{1'b1, 3'd3, 6'h04, 32'h1,        1'b1, 32'h0,         8'd6},   // R6
    '{1'b0, 3'd3, 6'h00, 32'h0,        1'b1, 32'h0,         8'd2},
    '{1'b1, 3'd4, 6'h10, 32'hFFFF_FFFF, 1'b0, 32'h0,        8'd9},   // R9 I/O
    '{1'b0, 3'd4, 6'h10, 32'h0,        1'b0, 32'hFFFF_FF01, 8'd9},
    '{1'b1, 3'd4, 6'h10, 32'h0000_C002, 1'b0, 32'h0,        8'd8},   // R8 I/O
    '{1'b0, 3'd4, 6'h10, 32'h0,        1'b0, 32'h0000_C001, 8'd8},
    '{1'b1, 3'd4, 6'h14, 32'hFFFF_FFFF, 1'b0, 32'h0,        8'd9},   // R9 memory
    '{1'b0, 3'd4, 6'h14, 32'h0,        1'b0, 32'hFFFF_F008, 8'd9},
    '{1'b1, 3'd4, 6'h14, 32'hE000_000F, 1'b0, 32'h0,        8'd8},   // R8 memory
    '{1'b0, 3'd4, 6'h14, 32'h0,        1'b0, 32'hE000_0008, 8'd8},
    '{1'b1, 3'd4, 6'h24, 32'hFFFF_FFFF, 1'b0, 32'h0,        8'd9},   // R9 last BAR
    '{1'b0, 3'd4, 6'h24, 32'h0,        1'b0, 32'hFFFF_FFF0, 8'd9},
    '{1'b1, 3'd4, 6'h30, 32'hFFFF_FFFE, 1'b0, 32'h0,        8'd10},  // R10
    '{1'b0, 3'd4, 6'h30, 32'h0,        1'b0, 32'hFFFF_FFFF, 8'd10},
    '{1'b1, 3'd4, 6'h30, 32'h00C0_0001, 1'b0, 32'h0,        8'd10},
    '{1'b0, 3'd4, 6'h30, 32'h0,        1'b0, 32'h00C0_0001, 8'd10},
    '{1'b1, 3'd4, 6'h00, 32'hDEAD_BEEF, 1'b1, 32'h0,        8'd11},  // R11
    '{1'b1, 3'd4, 6'h28, 32'h1,        1'b1, 32'h0,         8'd11},
    '{1'b1, 3'd4, 6'h12, 32'h1,        1'b1, 32'h0,         8'd11},
    '{1'b0, 3'd4, 6'h00, 32'h0,        1'b0, 32'h7301_1AB5, 8'd11},
    '{1'b0, 3'd4, 6'h10, 32'h0,        1'b0, 32'h0000_C001, 8'd11},
    '{1'b0, 3'd2, 6'h3F, 32'h0,        1'b1, 32'h0,         8'd2},   // R2 past end
    '{1'b0, 3'd1, 6'h3F, 32'h0,        1'b0, 32'h0000_0010, 8'd2},
    '{1'b0, 3'd4, 6'h2C, 32'h0,        1'b0, 32'h0042_1AB5, 8'd3},
    '{1'b1, 3'd2, 6'h05, 32'h1,        1'b1, 32'h0,         8'd5},
    '{1'b0, 3'd0, 6'h00, 32'h0,        1'b1, 32'h0,         8'd2}
  };

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive on a falling edge, sample the response on the next falling edge.
  task automatic doReq(input logic wr, input logic [2:0] sz, input logic [5:0] off,
                       input logic [31:0] wd, output logic rv, output logic re,
                       output logic [31:0] rd);
    reqValid  = 1'b1;
    reqWrite  = wr;
    reqSize   = sz;
    reqOffset = off;
    reqWdata  = wd;
    @(negedge clk);
    rv = rspValid;
    re = rspErr;
    rd = rspData;
    reqValid = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic rv, re;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("reset rspValid", 1, 32'(rspValid), 32'h0);  // R1
    check("reset rspErr", 1, 32'(rspErr), 32'h0);      // R1

    for (int i = 0; i < NVEC; i++) begin
      doReq(VEC[i].wr, VEC[i].sz, VEC[i].off, VEC[i].wd, rv, re, rd);
      check($sformatf("vec %0d valid", i), int'(VEC[i].req), 32'(rv), 32'h1);
      check($sformatf("vec %0d err", i), int'(VEC[i].req), 32'(re), 32'(VEC[i].err));
      check($sformatf("vec %0d data", i), int'(VEC[i].req), rd, VEC[i].rd);
    end

    // R1: idle cycle gives no response
    @(negedge clk);
    check("idle rspValid", 1, 32'(rspValid), 32'h0);

    // R3: reset mid-run restores the parameter image
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doReq(1'b0, 3'd4, 6'h10, 32'h0, rv, re, rd);
    check("BAR0 after reset", 3, rd, 32'h0000_0001);
    doReq(1'b0, 3'd4, 6'h04, 32'h0, rv, re, rd);
    check("cmd/status after reset", 3, rd, 32'h0290_0000);
    doReq(1'b0, 3'd4, 6'h14, 32'h0, rv, re, rd);
    check("BAR1 after reset", 3, rd, 32'h0000_0008);
    doReq(1'b0, 3'd4, 6'h3C, 32'h0, rv, re, rd);
    check("interrupt word after reset", 3, rd, 32'h1006_010B);

    // R8: I/O BAR keeps bit 1 on a normal write of zeros
    doReq(1'b1, 3'd4, 6'h10, 32'h0000_0000, rv, re, rd);
    doReq(1'b0, 3'd4, 6'h10, 32'h0, rv, re, rd);
    check("I/O BAR type bits kept", 8, rd, 32'h0000_0001);

    finish();
  end
endmodule